// File: doc/BRIEF.md
# Output protection and power-good supervisor

This block supervises the output of a step-down converter from a set of digital comparator flags taken at the feedback node: below 70 % of reference, below 90 % of reference, above 125 % of reference, plus an over-temperature flag. From these flags it produces a power-good output and the gate override commands for the switching stage. An undervoltage condition must persist for a debounce window before it latches both gates off and requests a controlled soft-stop. Undervoltage is ignored until the startup sequencer reports that soft-start has finished. An overvoltage condition must persist through a short noise filter before it latches the low-side switch fully on.

Power-good is asymmetric. It rises only after the feedback has been inside the good window for a full delay, and it falls in the same cycle that the feedback leaves the wide window. The latched faults are cleared only by taking enable low or by losing the supply-good flag. Over-temperature is not latched: it forces both gates off for as long as the flag is set, and the power-good delay runs again from zero once the flag clears. All timing is counted in clock cycles, and each window is a parameter.

Top module: `pwr_guard`

## Requirements
- R1: While `ss_done` is low, `fb_below_uv` can never latch the undervoltage fault, however long it is held.
- R2: With `en`, `por_good` and `ss_done` high, `fb_below_uv` sampled high on UV_DEBOUNCE_CYC consecutive rising edges latches the fault. From just after that edge, `force_both_off` and `soft_stop_req` are both 1, and they stay 1 after the flag returns low.
- R3: If the condition being qualified is sampled low on any edge before its window completes, the debounce or filter count restarts from zero. The undervoltage debounce, the overvoltage filter and the power-good delay all follow this rule.
- R4: `fb_above_ov` sampled high on OV_FILTER_CYC consecutive edges, while `en` and `por_good` are high, latches `force_low_side_on` to 1. It stays 1 after the flag returns low.
- R5: The overvoltage path is active whatever the state of `ss_done`.
- R6: `power_ok` rises just after PG_DELAY_CYC consecutive edges in which all of the following hold: `en` and `por_good` are high, no fault is latched, `over_temp` is low, and the three feedback flags are all low.
- R7: `power_ok` is 0 in the same cycle that `fb_below_uv` or `fb_above_ov` is 1. Once high, `power_ok` does not fall because of `fb_below_pg` alone.
- R8: While `en` or `por_good` is low, all four outputs are 0 in that same cycle. An edge that samples this state clears both latched faults.
- R9: While `en`, `por_good` and `over_temp` are all high, `force_both_off` is 1 and `power_ok` is 0, both in that cycle. Nothing is latched by `over_temp`: after it clears, `power_ok` needs a fresh PG_DELAY_CYC window.
- R10: `force_both_off` takes priority. When both faults are latched, `force_low_side_on` is 0, and the two gate commands are never 1 together.
- R11: While `rst` (synchronous, active high) is applied, and after its release, all outputs are 0 until one of the conditions above occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable; low clears latched faults |
| por_good | input | 1 | Supply above its power-on threshold; low clears latched faults |
| ss_done | input | 1 | Soft-start complete, from the startup sequencer |
| fb_below_uv | input | 1 | Feedback below 70 % of reference |
| fb_below_pg | input | 1 | Feedback below 90 % of reference |
| fb_above_ov | input | 1 | Feedback above 125 % of reference |
| over_temp | input | 1 | Junction over-temperature flag |
| power_ok | output | 1 | Power-good indication |
| force_low_side_on | output | 1 | Hold the low-side switch fully on (overvoltage) |
| force_both_off | output | 1 | Hold both switches off (undervoltage or over-temperature) |
| soft_stop_req | output | 1 | Request a controlled output discharge |

## Verification
Suppose a qualification counter fails to restart, or runs one cycle long or short. The first latch or `power_ok` rise would then show up one edge early or late, or after a glitch that should not count. Because the bench model is compared on every cycle, that error is caught in the exact cycle it appears. A fault latch that clears when it should not, or fails to clear, shows up as a gate command that is wrong while `en` and `por_good` are steady, or as a command that survives the single cycle of enable low. A missing gate on `power_ok` shows up in the same cycle that a wide-window flag or `over_temp` is raised.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

    // Index of each latched fault in the fault vector
    localparam int unsigned FLT_UV = 0;
    localparam int unsigned FLT_OV = 1;
    localparam int unsigned N_FLT  = 2;

    // Comparator flags seen at the feedback node and thermal sensor
    typedef struct packed {
        logic below_uv;
        logic below_pg;
        logic above_ov;
        logic over_temp;
    } fb_flags_t;

    // Latched fault state
    typedef struct packed {
        logic uv;
        logic ov;
    } fault_t;

    // Power-good may remain asserted only inside the wide window, with no fault
    function automatic logic pg_hold(fb_flags_t f, fault_t l);
        return !f.below_uv && !f.above_ov && !f.over_temp && !l.uv && !l.ov;
    endfunction

    // Power-good may start its delay only inside the narrow window
    function automatic logic pg_rise(fb_flags_t f, fault_t l);
        return pg_hold(f, l) && !f.below_pg;
    endfunction

    // Qualification window for a given fault index
    function automatic int unsigned flt_len(int unsigned idx, int unsigned uv_len,
                                            int unsigned ov_len);
        return (idx == FLT_UV) ? uv_len : ov_len;
    endfunction

endpackage

// File: rtl/pwr_guard_qual.sv
// Consecutive-cycle qualifier: fire is high on the edge where arm has been
// sampled high LEN times in a row. Any low sample restarts the count.
module pwr_guard_qual #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic arm,
    input  logic stop,
    output logic fire
);
    localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    assign fire = arm && !stop && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || stop || !arm || fire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: count never passes the end of its window
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
    // R3: a low sample restarts the window
    p_restart_r3: assert property (@(posedge clk) disable iff (rst) !arm |=> (cnt == '0));

endmodule

// File: rtl/pwr_guard_fault.sv
// One qualified fault with a sticky latch, cleared only by clr
module pwr_guard_fault #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic arm,
    output logic latched
);
    logic fire;

    pwr_guard_qual #(.LEN(LEN)) u_qual (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .arm  (arm),
        .stop (latched),
        .fire (fire)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            latched <= 1'b0;
        end else if (fire) begin
            latched <= 1'b1;
        end
    end

    // R2/R4: latch stays set while no clear is sampled
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (latched && !clr) |=> latched);
    // R8: a sampled clear empties the latch
    p_clear_r8: assert property (@(posedge clk) disable iff (rst) clr |=> !latched);

endmodule

// File: rtl/pwr_guard_pgood.sv
// Power-good tracker: delayed rise, immediate fall
module pwr_guard_pgood #(
    parameter int unsigned LEN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic hold,
    input  logic rise,
    output logic power_ok
);
    logic pg_state;
    logic fire;

    pwr_guard_qual #(.LEN(LEN)) u_qual (
        .clk  (clk),
        .rst  (rst),
        .clr  (!active),
        .arm  (rise),
        .stop (pg_state),
        .fire (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_state <= 1'b0;
        end else begin
            pg_state <= active && hold && (pg_state || fire);
        end
    end

    assign power_ok = pg_state && hold && active;

    // R6: state rises only after a qualifying sample
    p_pg_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_state) |-> $past(rise));
    // R7: leaving the wide window drops the output in the same cycle
    p_pg_drop_r7: assert property (@(posedge clk) disable iff (rst) !hold |-> !power_ok);

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
    import pwr_guard_pkg::*;
#(
    parameter int unsigned UV_DEBOUNCE_CYC = 2000,
    parameter int unsigned OV_FILTER_CYC   = 188,
    parameter int unsigned PG_DELAY_CYC    = 7875
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic por_good,
    input  logic ss_done,
    input  logic fb_below_uv,
    input  logic fb_below_pg,
    input  logic fb_above_ov,
    input  logic over_temp,
    output logic power_ok,
    output logic force_low_side_on,
    output logic force_both_off,
    output logic soft_stop_req
);
    logic             active;
    fb_flags_t        flags;
    fault_t           faults;
    logic [N_FLT-1:0] arm;
    logic [N_FLT-1:0] latched;
    logic             hold;
    logic             rise;

    assign active = en && por_good;
    assign flags  = '{below_uv: fb_below_uv, below_pg: fb_below_pg,
                      above_ov: fb_above_ov, over_temp: over_temp};

    // Undervoltage is masked until soft-start completes; overvoltage is not
    assign arm[FLT_UV] = active && ss_done && flags.below_uv;
    assign arm[FLT_OV] = active && flags.above_ov;

    for (genvar g = 0; g < N_FLT; g++) begin : g_flt
        localparam int unsigned L = flt_len(g, UV_DEBOUNCE_CYC, OV_FILTER_CYC);
        pwr_guard_fault #(.LEN(L)) u_fault (
            .clk     (clk),
            .rst     (rst),
            .clr     (!active),
            .arm     (arm[g]),
            .latched (latched[g])
        );
    end

    assign faults = '{uv: latched[FLT_UV], ov: latched[FLT_OV]};
    assign hold   = active && pg_hold(flags, faults);
    assign rise   = active && pg_rise(flags, faults);

    pwr_guard_pgood #(.LEN(PG_DELAY_CYC)) u_pgood (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .hold     (hold),
        .rise     (rise),
        .power_ok (power_ok)
    );

    assign force_both_off    = active && (faults.uv || flags.over_temp);
    assign force_low_side_on = active && faults.ov && !force_both_off;
    assign soft_stop_req     = active && faults.uv;

    // R1: no undervoltage latch while soft-start is still running
    p_uv_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (!ss_done && !latched[FLT_UV]) |=> !latched[FLT_UV]);
    // R2: a soft-stop request always comes with both gates off
    p_softstop_r2: assert property (@(posedge clk) disable iff (rst)
        soft_stop_req |-> force_both_off);
    // R8: losing enable or supply clears every latched fault
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !active |=> (latched == '0));
    // R9: over-temperature turns gates off and drops power-good at once
    p_ot_r9: assert property (@(posedge clk) disable iff (rst)
        (active && over_temp) |-> (force_both_off && !power_ok));
    // R10: gate commands are mutually exclusive
    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(force_low_side_on && force_both_off));

endmodule

// File: tb/pwr_guard_bench.sv
module pwr_guard_bench;
    localparam int UV = 20;
    localparam int OV = 5;
    localparam int PG = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, por_good = 0, ss_done = 0;
    logic fb_below_uv = 0, fb_below_pg = 0, fb_above_ov = 0, over_temp = 0;
    logic power_ok, force_low_side_on, force_both_off, soft_stop_req;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    string phase = "R11";

    // Reference model state
    int m_uv_n = 0, m_ov_n = 0, m_pg_n = 0;
    bit m_uv = 0, m_ov = 0, m_pg = 0;

    always #4 clk = ~clk;

    pwr_guard #(
        .UV_DEBOUNCE_CYC (UV),
        .OV_FILTER_CYC   (OV),
        .PG_DELAY_CYC    (PG)
    ) u_pwr_guard (
        .clk (clk), .rst (rst), .en (en), .por_good (por_good), .ss_done (ss_done),
        .fb_below_uv (fb_below_uv), .fb_below_pg (fb_below_pg),
        .fb_above_ov (fb_above_ov), .over_temp (over_temp),
        .power_ok (power_ok), .force_low_side_on (force_low_side_on),
        .force_both_off (force_both_off), .soft_stop_req (soft_stop_req)
    );

    // Behavioural model, advanced on each edge with the values sampled there
    always @(posedge clk) begin
        bit act, keep, good;
        if (rst) begin
            m_uv = 0; m_ov = 0; m_pg = 0; m_uv_n = 0; m_ov_n = 0; m_pg_n = 0;
        end else begin
            act  = en && por_good;
            keep = act && !m_uv && !m_ov && !over_temp && !fb_below_uv && !fb_above_ov;
            good = keep && !fb_below_pg;
            if (m_pg) begin
                m_pg = keep; m_pg_n = 0;
            end else if (good) begin
                m_pg_n++;
                if (m_pg_n == PG) begin m_pg = 1; m_pg_n = 0; end
            end else m_pg_n = 0;
            if (!act) begin
                m_uv = 0; m_ov = 0; m_uv_n = 0; m_ov_n = 0;
            end else begin
                if (!m_uv && ss_done && fb_below_uv) begin
                    m_uv_n++;
                    if (m_uv_n == UV) begin m_uv = 1; m_uv_n = 0; end
                end else m_uv_n = 0;
                if (!m_ov && fb_above_ov) begin
                    m_ov_n++;
                    if (m_ov_n == OV) begin m_ov = 1; m_ov_n = 0; end
                end else m_ov_n = 0;
            end
        end
    end

    function automatic logic [3:0] model_out();
        bit act, off, lo, ss, ok;
        act = en && por_good;
        off = act && (m_uv || over_temp);
        lo  = act && m_ov && !off;
        ss  = act && m_uv;
        ok  = act && m_pg && !m_uv && !m_ov && !over_temp && !fb_below_uv && !fb_above_ov;
        return {ok, lo, off, ss};
    endfunction

    // Compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        logic [3:0] act_v, exp_v;
        act_v = {power_ok, force_low_side_on, force_both_off, soft_stop_req};
        exp_v = model_out();
        vectors++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s cycle %0d outputs{ok,lo,off,ss} actual=%b expected=%b",
                     phase, cyc, act_v, exp_v);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic act_v, logic exp_v);
        vectors++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act_v, exp_v);
        end
    endtask

    initial begin
        step(3);
        phase = "R11";
        chk("R11", "reset force_both_off", force_both_off, 1'b0);
        chk("R11", "reset power_ok", power_ok, 1'b0);
        rst = 0;
        step(2);
        chk("R11", "post-reset force_low_side_on", force_low_side_on, 1'b0);

        // R1: undervoltage ignored during soft-start
        phase = "R1";
        en = 1; por_good = 1; ss_done = 0; fb_below_uv = 1; fb_below_pg = 1;
        step(50);
        chk("R1", "force_both_off masked", force_both_off, 1'b0);
        chk("R1", "soft_stop_req masked", soft_stop_req, 1'b0);

        // R6: delayed rise of power-good
        phase = "R6";
        fb_below_uv = 0; fb_below_pg = 0;
        step(PG - 1);
        chk("R6", "power_ok one edge early", power_ok, 1'b0);
        step(1);
        chk("R6", "power_ok after delay", power_ok, 1'b1);

        // R7: narrow-window flag alone keeps power-good
        phase = "R7";
        fb_below_pg = 1;
        step(10);
        chk("R7", "power_ok hold on below_pg", power_ok, 1'b1);
        fb_below_pg = 0; fb_above_ov = 1;
        #1;
        chk("R7", "power_ok immediate drop on ov", power_ok, 1'b0);

        // R3: interrupted overvoltage filter restarts
        phase = "R3";
        step(OV - 1);
        fb_above_ov = 0;
        step(1);
        fb_above_ov = 1;
        step(OV - 1);
        fb_above_ov = 0;
        step(1);
        chk("R3", "ov filter restarted", force_low_side_on, 1'b0);
        phase = "R6";
        step(PG);
        chk("R6", "power_ok regained", power_ok, 1'b1);

        // R3 and R2: interrupted then sustained undervoltage
        phase = "R3";
        ss_done = 1; fb_below_uv = 1;
        #1;
        chk("R7", "power_ok immediate drop on uv", power_ok, 1'b0);
        step(10);
        fb_below_uv = 0;
        step(1);
        fb_below_uv = 1;
        step(UV - 1);
        chk("R3", "uv debounce restarted", force_both_off, 1'b0);
        phase = "R2";
        step(1);
        chk("R2", "force_both_off latched", force_both_off, 1'b1);
        chk("R2", "soft_stop_req latched", soft_stop_req, 1'b1);
        fb_below_uv = 0;
        step(5);
        chk("R2", "uv latch persists", force_both_off, 1'b1);
        chk("R2", "power_ok low under fault", power_ok, 1'b0);

        // R8: enable low clears
        phase = "R8";
        en = 0;
        #1;
        chk("R8", "outputs off with en low", force_both_off, 1'b0);
        chk("R8", "soft_stop_req off with en low", soft_stop_req, 1'b0);
        step(1);
        en = 1;
        #1;
        chk("R8", "uv latch cleared", force_both_off, 1'b0);

        // R4/R5: overvoltage during soft-start
        phase = "R5";
        ss_done = 0; fb_above_ov = 1;
        step(OV);
        chk("R5", "ov acts during soft-start", force_low_side_on, 1'b1);
        phase = "R4";
        fb_above_ov = 0;
        step(3);
        chk("R4", "ov latch persists", force_low_side_on, 1'b1);

        // R10: both faults latched
        phase = "R10";
        ss_done = 1; fb_below_uv = 1;
        step(UV);
        chk("R10", "force_both_off wins", force_both_off, 1'b1);
        chk("R10", "force_low_side_on suppressed", force_low_side_on, 1'b0);
        fb_below_uv = 0;

        // R8: supply-good loss clears
        phase = "R8";
        por_good = 0;
        #1;
        chk("R8", "low side off with por low", force_low_side_on, 1'b0);
        step(1);
        por_good = 1;
        #1;
        chk("R8", "ov latch cleared", force_low_side_on, 1'b0);
        chk("R8", "uv latch cleared by por", force_both_off, 1'b0);

        // R9: over-temperature
        phase = "R9";
        step(PG);
        chk("R9", "power_ok before ot", power_ok, 1'b1);
        over_temp = 1;
        #1;
        chk("R9", "force_both_off on ot", force_both_off, 1'b1);
        chk("R9", "power_ok dropped on ot", power_ok, 1'b0);
        step(10);
        over_temp = 0;
        #1;
        chk("R9", "ot not latched", force_both_off, 1'b0);
        step(PG - 1);
        chk("R9", "power_ok waits fresh delay", power_ok, 1'b0);
        step(1);
        chk("R9", "power_ok after fresh delay", power_ok, 1'b1);

        step(5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule